// File: doc/BRIEF.md
# Time-Slotted Bus Master Cycle Scheduler

This block runs a fixed, repeating communication schedule for one master and up to fifteen slave nodes on a shared serial bus. At the start of each cycle it requests a broadcast timing packet, which every slave takes as the common time mark. It then polls each node with a read request and waits for that node's reply. Next it sends each node a write request and waits for that reply. Whatever time remains in the cycle is a free window, in which at most one pending aperiodic transfer is allowed onto the bus. Slaves never talk unless asked, so the schedule alone decides who uses the bus.

Every request goes to a packet layer through a valid/grant handshake. Each request carries a kind code and a node index. Replies come back as a one-cycle done strobe. Each node slot has a time budget, equal to a fixed fraction of the cycle length divided by the node count. A node that does not reply within its budget is marked in a timeout vector, and the schedule moves on to the next node. The cycle length, in clock cycles, and the node count are sampled only when a cycle begins.

Top module: `tdma_sched`

## Requirements
- R1: A cycle lasts exactly `cfg_period` clock cycles (values below 2 count as 2). The value is latched when the cycle begins, and a new cycle begins only when that count has elapsed, even if the free window went unused.
- R2: The first request of every cycle is the broadcast timing request, with kind code 0 and node 0. It is raised in the first clock of the cycle, which is the second clock after reset is released.
- R3: After the timing request is granted, the block sends read requests (kind code 1) to nodes 0, 1, … N-1 in ascending order. Each request is sent only after the previous node's slot has closed, and `req_node` is always below N.
- R4: After the read slot of node N-1 closes, the block sends write requests (kind code 2) to nodes 0 … N-1 in the same one-at-a-time manner.
- R5: After the last write slot closes, the block raises an aperiodic request (kind code 3, node 0) while `aper_pending` is high. It grants at most one such request per cycle and issues none when `aper_pending` stays low.
- R6: The slot budget is B = max(2, floor(floor(P·RATIO_NUM / 2^RATIO_SHIFT) / N)), which is P/2/N with the default parameters. A slot opens in the clock its request is raised. A done strobe is accepted only after the grant. A reply therefore closes the slot in the clock it arrives. Otherwise the slot closes after B clocks, and the next request comes exactly B clocks after the silent node's request.
- R7: Bit i of `timeout_flags` is set when node i's read or write slot closes without a reply. All bits clear when a cycle begins, and the flags hold until then.
- R8: N is latched from `cfg_nodes` only when a cycle begins (0 counts as 1, values above MAX_NODES count as MAX_NODES). Changing it in mid-cycle does not affect the running cycle, and no flag at or above N is ever set.
- R9: When the cycle count runs out before the schedule finishes, the open slot is dropped without setting its flag, and the next cycle begins on time.
- R10: A read, write or timing request holds `req_valid`, `req_kind` and `req_node` steady until it is granted, its slot closes, or a new cycle begins.
- R11: While reset is held, `req_valid` is low and `timeout_flags` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_period | input | PER_W | Cycle length in clock cycles |
| cfg_nodes | input | NODE_W | Number of slave nodes N |
| aper_pending | input | 1 | An aperiodic transfer is waiting |
| req_grant | input | 1 | Packet layer accepts the current request |
| rsp_done | input | 1 | One-cycle strobe: reply from the polled node arrived |
| req_valid | output | 1 | A request is offered |
| req_kind | output | 2 | 0 timing, 1 read, 2 write, 3 aperiodic |
| req_node | output | NODE_W | Target node of a read or write request |
| timeout_flags | output | MAX_NODES | Per-node timeout marks for the running cycle |

## Verification
On every clock, the assertions check that each cycle opens with the timing request and cleared flags, and that periodic requests stay steady while they wait for a grant. They also check that node indices and flags stay below the latched N, and that no more than one aperiodic grant occurs per cycle. The bench's scenarios are needed to show the things that only appear over a whole cycle. These are the exact cycle length, the strict read-then-write ordering, the slot budget computed from the period and N, the dropping of an open slot when the count runs out, and the fact that a mid-cycle change to N waits for the next cycle.

// File: rtl/tdma_pkg.sv
package tdma_pkg;

    typedef enum logic [1:0] {
        K_SYNC  = 2'd0,
        K_READ  = 2'd1,
        K_WRITE = 2'd2,
        K_APER  = 2'd3
    } kind_e;

    typedef enum logic [2:0] {
        S_BOOT,
        S_SYNC,
        S_RD_REQ,
        S_RD_WAIT,
        S_WR_REQ,
        S_WR_WAIT,
        S_APER,
        S_IDLE
    } state_e;

endpackage

// File: rtl/tdma_period.sv
module tdma_period #(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PER_W-1:0] cfg_period,
    input  logic             boot,
    output logic             start
);
    typedef struct packed {
        logic [PER_W-1:0] cnt;
        logic [PER_W-1:0] len;
    } per_t;

    per_t per_q, per_d;
    logic [PER_W-1:0] len_in;

    always_comb begin
        len_in = (cfg_period < PER_W'(2)) ? PER_W'(2) : cfg_period;
        start  = boot || (per_q.cnt == per_q.len - 1'b1);
        per_d  = per_q;
        if (start) begin
            per_d.cnt = '0;
            per_d.len = len_in;
        end else begin
            per_d.cnt = per_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_q.cnt <= '0;
            per_q.len <= PER_W'(2);
        end else begin
            per_q <= per_d;
        end
    end
endmodule

// File: rtl/tdma_budget.sv
module tdma_budget #(
    parameter int MAX_NODES   = 15,
    parameter int PER_W       = 16,
    parameter int RATIO_NUM   = 1,
    parameter int RATIO_SHIFT = 1,
    localparam int NODE_W     = $clog2(MAX_NODES + 1)
) (
    input  logic [PER_W-1:0]  cfg_period,
    input  logic [NODE_W-1:0] cfg_nodes,
    output logic [NODE_W-1:0] n_eff,
    output logic [PER_W-1:0]  budget
);
    localparam int PROD_W = PER_W + 8;

    logic [PER_W-1:0]  per_c;
    logic [PROD_W-1:0] scaled;
    logic [PROD_W-1:0] quot;

    always_comb begin
        if (cfg_nodes == '0)
            n_eff = NODE_W'(1);
        else if (cfg_nodes > NODE_W'(MAX_NODES))
            n_eff = NODE_W'(MAX_NODES);
        else
            n_eff = cfg_nodes;
        per_c  = (cfg_period < PER_W'(2)) ? PER_W'(2) : cfg_period;
        scaled = (PROD_W'(per_c) * PROD_W'(RATIO_NUM)) >> RATIO_SHIFT;
        quot   = scaled / PROD_W'(n_eff);
        budget = (quot < PROD_W'(2)) ? PER_W'(2) : quot[PER_W-1:0];
    end
endmodule

// File: rtl/tdma_sched.sv
module tdma_sched #(
    parameter int MAX_NODES   = 15,
    parameter int PER_W       = 16,
    parameter int RATIO_NUM   = 1,
    parameter int RATIO_SHIFT = 1,
    localparam int NODE_W     = $clog2(MAX_NODES + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PER_W-1:0]     cfg_period,
    input  logic [NODE_W-1:0]    cfg_nodes,
    input  logic                 aper_pending,
    input  logic                 req_grant,
    input  logic                 rsp_done,
    output logic                 req_valid,
    output logic [1:0]           req_kind,
    output logic [NODE_W-1:0]    req_node,
    output logic [MAX_NODES-1:0] timeout_flags
);
    import tdma_pkg::*;

    typedef struct packed {
        state_e               st;
        logic [NODE_W-1:0]    node;
        logic [NODE_W-1:0]    n;
        logic [PER_W-1:0]     budget;
        logic [PER_W-1:0]     slot;
        logic [MAX_NODES-1:0] flags;
    } sched_t;

    sched_t r_q, r_d;

    logic              start;
    logic [NODE_W-1:0] n_eff;
    logic [PER_W-1:0]  budget_in;
    logic              in_slot, waiting, is_wr, got, expire, slot_end;
    logic [NODE_W-1:0] n_cur;

    tdma_period #(.PER_W(PER_W)) u_period (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_period (cfg_period),
        .boot       (r_q.st == S_BOOT),
        .start      (start)
    );

    tdma_budget #(
        .MAX_NODES   (MAX_NODES),
        .PER_W       (PER_W),
        .RATIO_NUM   (RATIO_NUM),
        .RATIO_SHIFT (RATIO_SHIFT)
    ) u_budget (
        .cfg_period (cfg_period),
        .cfg_nodes  (cfg_nodes),
        .n_eff      (n_eff),
        .budget     (budget_in)
    );

    assign n_cur = r_q.n;

    always_comb begin
        in_slot  = (r_q.st == S_RD_REQ) || (r_q.st == S_RD_WAIT) ||
                   (r_q.st == S_WR_REQ) || (r_q.st == S_WR_WAIT);
        waiting  = (r_q.st == S_RD_WAIT) || (r_q.st == S_WR_WAIT);
        is_wr    = (r_q.st == S_WR_REQ) || (r_q.st == S_WR_WAIT);
        got      = waiting && rsp_done;
        expire   = (r_q.slot == r_q.budget - 1'b1);
        slot_end = in_slot && (got || expire);

        r_d = r_q;
        case (r_q.st)
            S_SYNC: begin
                if (req_grant) begin
                    r_d.st   = S_RD_REQ;
                    r_d.node = '0;
                    r_d.slot = '0;
                end
            end
            S_RD_REQ, S_RD_WAIT, S_WR_REQ, S_WR_WAIT: begin
                if (slot_end) begin
                    if (!got)
                        r_d.flags = r_q.flags | ({{(MAX_NODES-1){1'b0}}, 1'b1} << r_q.node);
                    r_d.slot = '0;
                    if (r_q.node == r_q.n - 1'b1) begin
                        r_d.node = '0;
                        r_d.st   = is_wr ? S_APER : S_WR_REQ;
                    end else begin
                        r_d.node = r_q.node + 1'b1;
                        r_d.st   = is_wr ? S_WR_REQ : S_RD_REQ;
                    end
                end else begin
                    r_d.slot = r_q.slot + 1'b1;
                    if (r_q.st == S_RD_REQ && req_grant) r_d.st = S_RD_WAIT;
                    if (r_q.st == S_WR_REQ && req_grant) r_d.st = S_WR_WAIT;
                end
            end
            S_APER: begin
                if (aper_pending && req_grant) r_d.st = S_IDLE;
            end
            default: ;
        endcase

        if (start) begin
            r_d.st     = S_SYNC;
            r_d.n      = n_eff;
            r_d.budget = budget_in;
            r_d.flags  = '0;
            r_d.node   = '0;
            r_d.slot   = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st     <= S_BOOT;
            r_q.node   <= '0;
            r_q.n      <= NODE_W'(1);
            r_q.budget <= PER_W'(2);
            r_q.slot   <= '0;
            r_q.flags  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        req_valid = 1'b0;
        req_kind  = K_SYNC;
        req_node  = '0;
        case (r_q.st)
            S_SYNC:   req_valid = 1'b1;
            S_RD_REQ: begin req_valid = 1'b1; req_kind = K_READ;  req_node = r_q.node; end
            S_WR_REQ: begin req_valid = 1'b1; req_kind = K_WRITE; req_node = r_q.node; end
            S_APER:   begin req_valid = aper_pending; req_kind = K_APER; end
            default: ;
        endcase
    end

    assign timeout_flags = r_q.flags;
endmodule

// File: rtl/tdma_sched_chk.sv
module tdma_sched_chk #(
    parameter int MAX_NODES = 15,
    parameter int NODE_W    = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start,
    input logic                 slot_end,
    input logic [NODE_W-1:0]    n_cur,
    input logic                 req_valid,
    input logic                 req_grant,
    input logic [1:0]           req_kind,
    input logic [NODE_W-1:0]    req_node,
    input logic [MAX_NODES-1:0] timeout_flags
);
    logic ap_seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            ap_seen_q <= 1'b0;
        else if (start)
            ap_seen_q <= 1'b0;
        else if (req_valid && req_grant && req_kind == 2'd3)
            ap_seen_q <= 1'b1;
    end

    // R2
    sync_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (req_valid && req_kind == 2'd0));

    // R7
    flags_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (timeout_flags == '0));

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_grant && req_kind != 2'd3 && !slot_end && !start)
        |=> (req_valid && $stable(req_kind) && $stable(req_node)));

    // R3
    node_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_node < n_cur));

    // R5
    one_aper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_grant && req_kind == 2'd3) |-> !ap_seen_q);

    // R8
    flags_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_flags >> n_cur) == '0);
endmodule

bind tdma_sched tdma_sched_chk #(.MAX_NODES(MAX_NODES), .NODE_W(NODE_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .slot_end      (slot_end),
    .n_cur         (n_cur),
    .req_valid     (req_valid),
    .req_grant     (req_grant),
    .req_kind      (req_kind),
    .req_node      (req_node),
    .timeout_flags (timeout_flags)
);

// File: tb/tdma_sched_test.sv
module tdma_sched_test;
    localparam int MAXN = 15;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] cfg_period;
    logic [3:0]  cfg_nodes;
    logic        aper_pending;
    logic        req_grant;
    logic        rsp_done;
    logic        req_valid;
    logic [1:0]  req_kind;
    logic [3:0]  req_node;
    logic [14:0] timeout_flags;

    always #10 clk = ~clk;

    tdma_sched uut (
        .clk(clk), .rst_n(rst_n), .cfg_period(cfg_period), .cfg_nodes(cfg_nodes),
        .aper_pending(aper_pending), .req_grant(req_grant), .rsp_done(rsp_done),
        .req_valid(req_valid), .req_kind(req_kind), .req_node(req_node),
        .timeout_flags(timeout_flags)
    );

    typedef struct packed {
        logic [15:0] per;
        logic [3:0]  nodes;
        logic        ap;
        logic [14:0] mask;
        logic [14:0] flags;
        logic [4:0]  rd;
        logic [4:0]  wr;
        logic [1:0]  apc;
    } row_t;

    // period, nodes, aperiodic pending, silent-node mask, expected flags, reads, writes, aperiodic
    localparam row_t ROWS [7] = '{
        '{16'd200, 4'd3,  1'b1, 15'h0000, 15'h0000, 5'd3,  5'd3,  2'd1},
        '{16'd200, 4'd3,  1'b0, 15'h0002, 15'h0002, 5'd3,  5'd3,  2'd0},
        '{16'd400, 4'd15, 1'b1, 15'h0000, 15'h0000, 5'd15, 5'd15, 2'd1},
        '{16'd100, 4'd1,  1'b1, 15'h0001, 15'h0001, 5'd1,  5'd1,  2'd0},
        '{16'd100, 4'd0,  1'b1, 15'h0000, 15'h0000, 5'd1,  5'd1,  2'd1},
        '{16'd300, 4'd15, 1'b1, 15'h0001, 15'h0001, 5'd15, 5'd15, 2'd1},
        '{16'd90,  4'd15, 1'b1, 15'h0000, 15'h0000, 5'd15, 5'd15, 2'd0}
    };

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int syncs = 0;
    int sync_cyc, n_cur, bud_cur, idx, dcnt, last_evt;
    int rd_c, wr_c, ap_c, ord_e, gap_e;
    int last_rd, last_wr, last_ap, last_ord, last_gap, last_len;
    bit prev_slot, prev_silent, hold;
    logic [14:0] mask, prev_flags, last_flags;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) cyc++;

    // Packet-layer model: grants at once, replies two clocks after a grant unless the node is silent.
    always @(negedge clk) begin
        if (!rst_n) begin
            req_grant = 1'b0;
            rsp_done  = 1'b0;
            dcnt      = 0;
            prev_slot = 1'b0;
        end else begin
            rsp_done = 1'b0;
            if (dcnt > 0) begin
                dcnt--;
                if (dcnt == 0) rsp_done = 1'b1;
            end
            req_grant = req_valid && !hold;
            if (req_valid && !hold) begin
                if (req_kind == 2'd0) begin
                    if (syncs > 0) begin
                        last_rd = rd_c; last_wr = wr_c; last_ap = ap_c;
                        last_ord = ord_e; last_gap = gap_e;
                        last_len = cyc - sync_cyc; last_flags = prev_flags;
                    end
                    if (req_node != 0) ord_e++;
                    sync_cyc = cyc;
                    syncs++;
                    n_cur   = (cfg_nodes == 0) ? 1 : int'(cfg_nodes);
                    bud_cur = (int'(cfg_period) / 2) / n_cur;
                    if (bud_cur < 2) bud_cur = 2;
                    rd_c = 0; wr_c = 0; ap_c = 0; ord_e = 0; gap_e = 0; idx = 0;
                    prev_slot = 1'b0;
                end else begin
                    int ek, en;
                    if (idx < n_cur) begin ek = 1; en = idx; end
                    else if (idx < 2 * n_cur) begin ek = 2; en = idx - n_cur; end
                    else begin ek = 3; en = 0; end
                    if (int'(req_kind) != ek || int'(req_node) != en) ord_e++;
                    if (prev_slot) begin
                        if ((cyc - last_evt) != (prev_silent ? bud_cur : 3)) gap_e++;
                    end
                    if (req_kind == 2'd1) rd_c++;
                    if (req_kind == 2'd2) wr_c++;
                    if (req_kind == 2'd3) ap_c++;
                    idx++;
                    prev_slot   = (req_kind == 2'd1) || (req_kind == 2'd2);
                    prev_silent = mask[req_node];
                    last_evt    = cyc;
                    if (prev_slot && !prev_silent) dcnt = 2;
                end
            end
            prev_flags = timeout_flags;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R1 watchdog: actual=hung expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int k;
        rst_n = 1'b0; hold = 1'b0; mask = '0;
        cfg_period = ROWS[0].per; cfg_nodes = ROWS[0].nodes; aper_pending = ROWS[0].ap;
        repeat (3) @(negedge clk);
        chk("R11 req_valid in reset", req_valid, 0);
        chk("R11 flags in reset", timeout_flags, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 first request valid", req_valid, 1);
        chk("R2 first request kind", req_kind, 0);

        for (int i = 0; i < 7; i++) begin
            @(negedge clk); #1;
            cfg_period = ROWS[i].per; cfg_nodes = ROWS[i].nodes;
            aper_pending = ROWS[i].ap; mask = ROWS[i].mask;
            k = syncs;
            wait (syncs == k + 2);
            chk("R1 cycle length", last_len, int'(ROWS[i].per));
            chk("R3 read count", last_rd, int'(ROWS[i].rd));
            chk("R4 write count", last_wr, int'(ROWS[i].wr));
            chk("R5 aperiodic count", last_ap, int'(ROWS[i].apc));
            chk("R7 timeout flags", last_flags, int'(ROWS[i].flags));
            chk("R3 R4 request order", last_ord, 0);
            chk("R6 slot spacing", last_gap, 0);
            // rows 4 and 7 run out of time mid-schedule; row 5 uses N=0 (R8)
            if (i == 3 || i == 6) chk("R9 overrun drops slot", last_flags, int'(ROWS[i].flags));
        end

        // R8: N changed during a running cycle
        @(negedge clk); #1;
        cfg_period = 16'd200; cfg_nodes = 4'd5; aper_pending = 1'b1; mask = '0;
        k = syncs;
        wait (syncs == k + 1);
        #1 cfg_nodes = 4'd2;
        wait (syncs == k + 2);
        chk("R8 running cycle keeps N", last_rd, 5);
        wait (syncs == k + 3);
        chk("R8 next cycle takes N", last_rd, 2);

        // R10: withheld grant keeps the read request steady
        k = syncs;
        wait (syncs == k + 1);
        #1 hold = 1'b1;
        for (int j = 0; j < 4; j++) begin
            @(negedge clk);
            chk("R10 held valid", req_valid, 1);
            chk("R10 held kind", req_kind, 1);
            chk("R10 held node", req_node, 0);
        end
        #1 hold = 1'b0;

        repeat (20) @(negedge clk);
        #1 rst_n = 1'b0;
        @(negedge clk);
        chk("R11 req_valid after reset", req_valid, 0);
        chk("R11 flags after reset", timeout_flags, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule